// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command interpreter that sits behind the bus pins of a byte-wide parallel NOR flash. It watches host write cycles, which arrive as address and data pairs qualified by active-low chip-enable, write-enable and output-enable. From them it recognises the unlock handshake followed by a command byte. The recognised operations are byte program, unlock-bypass program, sector erase, chip erase, device identification, erase suspend/resume and the reset command. Any write that does not fit the expected sequence drops the interpreter back to plain array reads.

The block also decides what a host read returns: array bytes, identification codes, or a status byte. The status byte carries the complement of the programmed data bit 7 and a bit that alternates on every read while an operation is running. A counter-based engine stands in for the slow program and erase algorithms. A small behavioural byte memory stands in for the cell array. Programming can only clear bits. Erase walks the array twice: first it clears the selected sectors to 00h, then it sets them to FFh. Unlock cycles write AAh to 555h and then 55h to 2AAh; both addresses are compared on the low 11 address bits.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After rst_n is released the block is in array-read mode: busy is 0, and a read returns the stored byte (FFh when never programmed) with no command written first.
- R2: The four writes AAh@555h, 55h@2AAh, A0h@555h, then D@A start a program; busy rises, and afterwards address A holds its old value AND D, so bits only go from 1 to 0.
- R3: A write whose address or data breaks the expected sequence returns the block to array-read mode, so the writes that follow it (for example A0h@555h, then a data byte) change nothing.
- R4: A write is registered only while ce_n=0, we_n=0 and oe_n=1. The address is taken in the first cycle of the write and the data in its last cycle, and a write pulse with oe_n=0 has no effect.
- R5: While a program runs, every read returns status: bit 7 is the inverse of bit 7 of the written data, bit 6 starts at 0 after the command and inverts after each completed read, and bits 5:0 are 0. busy stays 1 for PROG_CYC cycles.
- R6: Holding rst_n low during an operation abandons it. busy is 0 after release, the target byte keeps its old value, and array reads work again.
- R7: Command byte 90h after the unlock enters identification mode. A read with address bits 1:0 = 00 returns 01h, 01 returns EDh (TOP_BOOT=1) or 6Dh (TOP_BOOT=0), and 10 returns 00h. Other writes leave the mode unchanged, and only F0h leaves it.
- R8: Command byte 20h enters bypass mode, in which A0h at any address followed by D@A programs a byte, and the block then stays in bypass mode. Any other write in bypass mode returns the block to array-read mode.
- R9: 80h, AAh@555h, 55h@2AAh, then 30h at a sector address (sector = address bits 10:8) selects that sector. Further 30h writes within WIN_CYC cycles add more sectors. The selected sectors end at FFh and the others are left unchanged. Reads during the erase return status with bit 7 = 0.
- R10: The same prefix followed by 10h@555h erases the whole array to FFh.
- R11: Writing B0h during an erase suspends it and busy drops. Reads outside the selected sectors return array data, and reads inside them return status with bit 7 = 0 and bit 6 held constant. Writing 30h resumes the erase, which then completes.
- R12: While suspended, a full program sequence to an unselected sector is carried out and the block returns to the suspended state. A program to a selected sector is ignored.
- R13: When ce_n or oe_n is 1, rdata is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the bus |
| rst_n | input | 1 | Active-low hardware reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: array, identification code or status |
| busy | output | 1 | High while a program or erase is running |

## Verification
The hardest state to reach is a program issued from inside a suspended erase. The erase must first be in its walking phase, which means the sector-collection window has closed, and it must then be frozen before its walk reaches the selected sector. The stimulus issues a single-sector erase and waits a fixed number of cycles past the window. It then writes B0h, runs a program to a different sector and a program to the suspended sector, and resumes. Address capture at the start of a write pulse and data capture at its end are exercised by changing both buses in the middle of one long write pulse.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [4:0] {
    ST_READ, ST_CY1, ST_CY2, ST_PGM, ST_ER1, ST_ER2, ST_ER3, ST_ERWIN,
    ST_AUTO, ST_BYP, ST_BYPP, ST_PBUSY, ST_EBUSY, ST_SUSP, ST_SU1,
    ST_SU2, ST_SUPGM, ST_SPBUSY
  } cmd_state_e;

  localparam logic [10:0] UL_ADDR_A = 11'h555;
  localparam logic [10:0] UL_ADDR_B = 11'h2AA;
  localparam logic [7:0]  UL_DATA_A = 8'hAA;
  localparam logic [7:0]  UL_DATA_B = 8'h55;
  localparam logic [7:0]  CMD_PGM   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_IDENT = 8'h90;
  localparam logic [7:0]  CMD_BYP   = 8'h20;
  localparam logic [7:0]  CMD_RESET = 8'hF0;
  localparam logic [7:0]  CMD_SUSP  = 8'hB0;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;

  // programming can only pull bits low
  function automatic logic [7:0] pgm_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // status byte: inverted data bit, alternating bit, rest zero
  function automatic logic [7:0] status_byte(input logic poll_bit, input logic alt_bit);
    return {poll_bit, alt_bit, 6'b000000};
  endfunction

  function automatic logic [7:0] ident_code(input logic [1:0] off, input logic top);
    case (off)
      2'd0:    return 8'h01;
      2'd1:    return top ? 8'hED : 8'h6D;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nor_bus_cap.sv
module nor_bus_cap #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              wr_evt,
  output logic              wr_open,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_on,
  output logic              rd_end
);
  logic wr_cond;
  logic rd_q;

  assign wr_cond = !ce_n && !we_n && oe_n;
  assign rd_on   = !ce_n && !oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open <= 1'b0;
      rd_q    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_open <= wr_cond;
      rd_q    <= rd_on;
      if (wr_cond && !wr_open) wr_addr <= addr;   // first cycle of the pulse
      if (wr_cond)             wr_data <= wdata;  // last value before it ends
    end
  end

  assign wr_evt = wr_open && !wr_cond;
  assign rd_end = rd_q && !rd_on;
endmodule

// File: rtl/nor_arr.sv
module nor_arr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdat,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [7:0]        rdat_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [7:0]        rdat_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdat;
  end

  assign rdat_a = mem[raddr_a];
  assign rdat_b = mem[raddr_b];
endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int SEC_W    = 3,
  parameter int PROG_CYC = 20,
  parameter int WIN_CYC  = 16,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_on,
  input  logic              rd_end,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rd,
  input  logic [7:0]        arr_old,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_wa,
  output logic [7:0]        arr_wd,
  output logic [7:0]        rdata,
  output logic              busy,
  output logic              tog,
  output logic              erasing
);
  localparam int NSEC  = 1 << SEC_W;
  localparam int CMAX  = (PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC;
  localparam int CNT_W = $clog2(CMAX + 1);

  cmd_state_e        st;
  logic              ret_byp;
  logic [ADDR_W-1:0] pa;
  logic [7:0]        pd;
  logic [CNT_W-1:0]  cnt;
  logic [NSEC-1:0]   sel;
  logic [ADDR_W-1:0] widx;
  logic              phase;

  function automatic logic [SEC_W-1:0] sec_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SEC_W];
  endfunction

  logic ul_a, ul_b, at_cmd, pgm_busy, pgm_done;
  assign ul_a     = (wr_addr[10:0] == UL_ADDR_A) && (wr_data == UL_DATA_A);
  assign ul_b     = (wr_addr[10:0] == UL_ADDR_B) && (wr_data == UL_DATA_B);
  assign at_cmd   = (wr_addr[10:0] == UL_ADDR_A);
  assign pgm_busy = (st == ST_PBUSY) || (st == ST_SPBUSY);
  assign pgm_done = pgm_busy && (cnt == CNT_W'(PROG_CYC - 1));
  assign erasing  = (st == ST_EBUSY);
  assign busy     = pgm_busy || erasing || (st == ST_ERWIN);

  // array write port shared by the program commit and the erase walker
  assign arr_wa = erasing ? widx : pa;
  assign arr_we = pgm_done || (erasing && sel[sec_of(widx)]);
  assign arr_wd = erasing ? (phase ? 8'hFF : 8'h00) : pgm_merge(arr_old, pd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_READ;
      ret_byp <= 1'b0;
      pa      <= '0;
      pd      <= '0;
      cnt     <= '0;
      sel     <= '0;
      widx    <= '0;
      phase   <= 1'b0;
      tog     <= 1'b0;
    end else begin
      if (busy && rd_end) tog <= ~tog;

      // engine progress
      case (st)
        ST_PBUSY, ST_SPBUSY: begin
          if (pgm_done) begin
            if (st == ST_SPBUSY) st <= ST_SUSP;
            else                 st <= ret_byp ? ST_BYP : ST_READ;
          end else cnt <= cnt + 1'b1;
        end
        ST_ERWIN: begin
          if (cnt == CNT_W'(WIN_CYC - 1)) begin
            st    <= ST_EBUSY;
            widx  <= '0;
            phase <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        ST_EBUSY: begin
          widx <= widx + 1'b1;
          if (widx == '1) begin
            if (phase) begin
              st  <= ST_READ;
              sel <= '0;
            end
            phase <= 1'b1;
          end
        end
        default: ;
      endcase

      // command decoding
      if (wr_evt) begin
        case (st)
          ST_READ: st <= ul_a ? ST_CY1 : ST_READ;
          ST_CY1:  st <= ul_b ? ST_CY2 : ST_READ;
          ST_CY2: begin
            st <= ST_READ;
            if (at_cmd) begin
              case (wr_data)
                CMD_PGM:   st <= ST_PGM;
                CMD_ERASE: st <= ST_ER1;
                CMD_IDENT: st <= ST_AUTO;
                CMD_BYP:   st <= ST_BYP;
                default:   st <= ST_READ;
              endcase
            end
          end
          ST_PGM, ST_BYPP: begin
            pa      <= wr_addr;
            pd      <= wr_data;
            cnt     <= '0;
            tog     <= 1'b0;
            ret_byp <= (st == ST_BYPP);
            st      <= ST_PBUSY;
          end
          ST_ER1: st <= ul_a ? ST_ER2 : ST_READ;
          ST_ER2: st <= ul_b ? ST_ER3 : ST_READ;
          ST_ER3: begin
            if (wr_data == CMD_SECT) begin
              sel <= '0;
              sel[sec_of(wr_addr)] <= 1'b1;
              cnt <= '0;
              tog <= 1'b0;
              st  <= ST_ERWIN;
            end else if (wr_data == CMD_CHIP && at_cmd) begin
              sel   <= '1;
              widx  <= '0;
              phase <= 1'b0;
              tog   <= 1'b0;
              st    <= ST_EBUSY;
            end else st <= ST_READ;
          end
          ST_ERWIN: begin
            if (wr_data == CMD_SECT) begin
              sel[sec_of(wr_addr)] <= 1'b1;
              cnt <= '0;
              st  <= ST_ERWIN;
            end else begin
              sel <= '0;
              st  <= ST_READ;
            end
          end
          ST_AUTO: if (wr_data == CMD_RESET) st <= ST_READ;
          ST_BYP:  st <= (wr_data == CMD_PGM) ? ST_BYPP : ST_READ;
          ST_EBUSY: if (wr_data == CMD_SUSP) st <= ST_SUSP;
          ST_SUSP: begin
            if (ul_a) st <= ST_SU1;
            else if (wr_data == CMD_SECT) st <= ST_EBUSY;
          end
          ST_SU1: st <= ul_b ? ST_SU2 : ST_SUSP;
          ST_SU2: st <= (at_cmd && wr_data == CMD_PGM) ? ST_SUPGM : ST_SUSP;
          ST_SUPGM: begin
            if (sel[sec_of(wr_addr)]) st <= ST_SUSP;
            else begin
              pa  <= wr_addr;
              pd  <= wr_data;
              cnt <= '0;
              tog <= 1'b0;
              st  <= ST_SPBUSY;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // read path selection
  always_comb begin
    rdata = 8'h00;
    if (rd_on) begin
      case (st)
        ST_PBUSY, ST_SPBUSY: rdata = status_byte(~pd[7], tog);
        ST_EBUSY, ST_ERWIN:  rdata = status_byte(1'b0, tog);
        ST_SUSP, ST_SU1, ST_SU2, ST_SUPGM:
          rdata = sel[sec_of(rd_addr)] ? status_byte(1'b0, tog) : arr_rd;
        ST_AUTO: rdata = ident_code(rd_addr[1:0], TOP_BOOT);
        default: rdata = arr_rd;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int ADDR_W   = 11,
  parameter int SEC_W    = 3,
  parameter int PROG_CYC = 20,
  parameter int WIN_CYC  = 16,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy
);
  logic              wr_evt, wr_open, rd_on, rd_end;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_wa;
  logic [7:0]        arr_wd, arr_rd, arr_old;
  logic              tog, erasing;

  nor_bus_cap #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .wr_evt(wr_evt), .wr_open(wr_open),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_on(rd_on), .rd_end(rd_end)
  );

  nor_arr #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_wa), .wdat(arr_wd),
    .raddr_a(addr), .rdat_a(arr_rd), .raddr_b(arr_wa), .rdat_b(arr_old)
  );

  nor_seq #(
    .ADDR_W(ADDR_W), .SEC_W(SEC_W), .PROG_CYC(PROG_CYC),
    .WIN_CYC(WIN_CYC), .TOP_BOOT(TOP_BOOT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_on(rd_on), .rd_end(rd_end), .rd_addr(addr),
    .arr_rd(arr_rd), .arr_old(arr_old), .arr_we(arr_we), .arr_wa(arr_wa),
    .arr_wd(arr_wd), .rdata(rdata), .busy(busy), .tog(tog), .erasing(erasing)
  );
endmodule

// File: rtl/nor_cmd_chk.sv
module nor_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic [7:0] rdata,
  input logic       busy,
  input logic       tog,
  input logic       arr_we,
  input logic [7:0] arr_wd,
  input logic [7:0] arr_old,
  input logic       erasing,
  input logic       wr_open
);
  // R2
  prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !erasing) |-> ((arr_wd & ~arr_old) == 8'h00));

  // R9
  erase_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && erasing) |-> (arr_wd == 8'h00 || arr_wd == 8'hFF));

  // R5
  tog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(tog) || busy));

  // R13
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (rdata == 8'h00));

  // R4
  oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> !wr_open);
endmodule

bind nor_cmd_ctrl nor_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .rdata(rdata),
  .busy(busy), .tog(tog), .arr_we(arr_we), .arr_wd(arr_wd),
  .arr_old(arr_old), .erasing(erasing), .wr_open(wr_open)
);

// File: tb/test_nor_cmd_ctrl.sv
`timescale 1ns/1ps
module test_nor_cmd_ctrl;
  localparam int AW = 11;
  localparam int WIN = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          busy;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nor_cmd_ctrl #(.ADDR_W(AW), .SEC_W(3), .PROG_CYC(20), .WIN_CYC(WIN), .TOP_BOOT(1'b1)) i_nor_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  // vector fields: req[32:29] kind[28:27] addr[26:16] data[15:8] exp[7:0]
  // kind 0 = write, 1 = read and compare, 2 = wait for busy low
  function automatic logic [32:0] mk(input int rq, input int k, input int a, input int d, input int e);
    return {4'(rq), 2'(k), 11'(a), 8'(d), 8'(e)};
  endfunction

  localparam int NV = 43;
  localparam logic [32:0] VEC [NV] = '{
    // R1 erased array readable without a command
    mk(1,1,'h100,0,'hFF),
    // R2 four-cycle program, then a second program that only clears bits
    mk(2,0,'h555,'hAA,0), mk(2,0,'h2AA,'h55,0), mk(2,0,'h555,'hA0,0), mk(2,0,'h100,'h5A,0),
    mk(2,2,0,0,0), mk(2,1,'h100,0,'h5A),
    mk(2,0,'h555,'hAA,0), mk(2,0,'h2AA,'h55,0), mk(2,0,'h555,'hA0,0), mk(2,0,'h100,'hF0,0),
    mk(2,2,0,0,0), mk(2,1,'h100,0,'h50),
    // R7 identification codes, stray write ignored, F0 exits
    mk(7,0,'h555,'hAA,0), mk(7,0,'h2AA,'h55,0), mk(7,0,'h555,'h90,0),
    mk(7,1,'h000,0,'h01), mk(7,1,'h001,0,'hED), mk(7,1,'h002,0,'h00),
    mk(7,0,'h123,'h77,0), mk(7,1,'h001,0,'hED), mk(7,0,'h000,'hF0,0), mk(7,1,'h100,0,'h50),
    // R3 wrong second unlock address aborts the sequence
    mk(3,0,'h555,'hAA,0), mk(3,0,'h2AB,'h55,0), mk(3,0,'h555,'hA0,0), mk(3,0,'h200,'h00,0),
    mk(3,1,'h200,0,'hFF),
    // R8 bypass: two-write programs, then exit on any other write
    mk(8,0,'h555,'hAA,0), mk(8,0,'h2AA,'h55,0), mk(8,0,'h555,'h20,0),
    mk(8,0,'h000,'hA0,0), mk(8,0,'h300,'h0F,0), mk(8,2,0,0,0), mk(8,1,'h300,0,'h0F),
    mk(8,0,'h111,'hA0,0), mk(8,0,'h301,'h3C,0), mk(8,2,0,0,0), mk(8,1,'h301,0,'h3C),
    mk(8,0,'h000,'hF0,0), mk(8,0,'h000,'hA0,0), mk(8,0,'h302,'h00,0), mk(8,1,'h302,0,'hFF)
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #2 v = rdata;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock3(input logic [7:0] c);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, c);
  endtask

  task automatic wait_idle(input string tag, input int lim);
    int n = 0;
    while (busy === 1'b1 && n < lim) begin
      @(negedge clk);
      n++;
    end
    total++;
    if (busy !== 1'b0) begin
      bad++;
      $display("FAIL %s busy stuck got=%0b exp=0", tag, busy);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy after reset", {7'd0, busy}, 8'h00);
    // R13 idle bus drives zero
    chk("R13 idle rdata", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", int'(VEC[i][32:29]), i);
      case (VEC[i][28:27])
        2'd0: wr(VEC[i][26:16], VEC[i][15:8]);
        2'd1: begin rd(VEC[i][26:16], v); chk(tg, v, VEC[i][7:0]); end
        default: wait_idle(tg, 200);
      endcase
    end

    // R13 ce high with oe low, and ce low with oe high
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; #2 chk("R13 ce high", rdata, 8'h00);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #2 chk("R13 oe high", rdata, 8'h00);
    @(negedge clk); ce_n = 1'b1;

    // R4 write with oe low ignored; address from start, data from end of pulse
    unlock3(8'hA0);
    @(negedge clk); addr = 11'h400; wdata = 8'h00; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    chk("R4 oe-low write ignored", {7'd0, busy}, 8'h00);
    @(negedge clk); addr = 11'h400; wdata = 8'h00; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = 11'h401; wdata = 8'h3C;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    wait_idle("R4 program", 200);
    rd(11'h400, v); chk("R4 start address, end data", v, 8'h3C);
    rd(11'h401, v); chk("R4 later address untouched", v, 8'hFF);

    // R5 status while programming
    unlock3(8'hA0); wr(11'h500, 8'h12);
    chk("R5 busy during program", {7'd0, busy}, 8'h01);
    rd(11'h500, v); chk("R5 first status", v, 8'h80);
    rd(11'h500, v); chk("R5 second status", v, 8'hC0);
    wait_idle("R5 program", 200);
    rd(11'h500, v); chk("R5 result", v, 8'h12);
    unlock3(8'hA0); wr(11'h501, 8'h80);
    rd(11'h123, v); chk("R5 status bit7 clear", v, 8'h00);
    wait_idle("R5 program2", 200);

    // R6 hardware reset abandons a program
    unlock3(8'hA0); wr(11'h600, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 busy after reset", {7'd0, busy}, 8'h00);
    rd(11'h600, v); chk("R6 target unchanged", v, 8'hFF);

    // R9 two-sector erase (sectors 1 and 3)
    unlock3(8'h80); wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
    wr(11'h100, 8'h30); wr(11'h300, 8'h30);
    rd(11'h700, v); chk("R9 status bit7 in erase", v & 8'h80, 8'h00);
    wait_idle("R9 erase", 12000);
    rd(11'h100, v); chk("R9 sector1 erased", v, 8'hFF);
    rd(11'h301, v); chk("R9 sector3 erased", v, 8'hFF);
    rd(11'h400, v); chk("R9 sector4 kept", v, 8'h3C);

    // R11 suspend an erase of sector 4
    unlock3(8'h80); wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
    wr(11'h400, 8'h30);
    repeat (WIN + 8) @(negedge clk);
    wr(11'h000, 8'hB0);
    chk("R11 busy low in suspend", {7'd0, busy}, 8'h00);
    rd(11'h500, v); chk("R11 outside sector reads array", v, 8'h12);
    rd(11'h400, v); rd(11'h400, v2);
    chk("R11 inside sector status", v & 8'hBF, 8'h00);
    chk("R11 toggle frozen", v2, v);
    // R12 program elsewhere while suspended
    unlock3(8'hA0); wr(11'h600, 8'h33);
    wait_idle("R12 suspended program", 200);
    rd(11'h600, v); chk("R12 program done in suspend", v, 8'h33);
    rd(11'h400, v); chk("R12 back in suspend", v & 8'hBF, 8'h00);
    unlock3(8'hA0); wr(11'h410, 8'h00);
    chk("R12 program to suspended sector ignored", {7'd0, busy}, 8'h00);
    wr(11'h000, 8'h30);
    chk("R11 resume sets busy", {7'd0, busy}, 8'h01);
    wait_idle("R11 resumed erase", 12000);
    rd(11'h400, v); chk("R11 sector4 erased", v, 8'hFF);
    rd(11'h410, v); chk("R12 suspended byte erased", v, 8'hFF);
    rd(11'h600, v); chk("R12 other sector kept", v, 8'h33);

    // R10 chip erase
    unlock3(8'h80); wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
    wait_idle("R10 chip erase", 12000);
    rd(11'h500, v); chk("R10 byte 500", v, 8'hFF);
    rd(11'h600, v); chk("R10 byte 600", v, 8'hFF);
    rd(11'h7FF, v); chk("R10 last byte", v, 8'hFF);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule